// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 level-sensitive interrupt sources and presents a single prioritized request to a processor. Each source carries a 4-bit priority and an enable bit. Among the sources that are asserted, enabled, given a nonzero priority and mapped to a vector, the block picks a winner. It drives out the winner's priority level and a 12-bit vector code. The interrupt line rises only when that level exceeds a mask level supplied from outside.

Software reaches the block through a simple word register bus. Enables are never written directly. One pair of addresses sets enable bits and another pair clears them, so independent drivers can change their own sources without a read-modify-write. The control word is handled the same way. Priorities are packed eight 4-bit fields per word. The raw inputs and the resulting request vector can be read back for polling.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every priority field and the control bit are zero, and irq_out, irq_level and irq_code are zero.
- R2: A write to offset 0x70 (sources 0-31) or 0x78 (sources 32-63, bit = source-32) sets each enable bit whose data bit is 1 and leaves bits written with 0 unchanged. Reads of 0x70/0x78 and of 0x80/0x88 return the current enable bits.
- R3: A write to 0x80 or 0x88 clears each enable bit whose data bit is 1. Writing all ones to both disables all 64 sources.
- R4: Priority word k sits at offset 0x10 + 8*k (k = 0..7) and reads back as written. Source i takes its priority from word i/8, bits [(i%8)*4 +: 4].
- R5: Writing data bit 0 = 1 to offset 0x00 sets the line-mode bit, and writing it to 0x08 clears it. Bit 0 of a read at either offset returns the bit, which also drives line_mode.
- R6: Offsets 0x50/0x58 return the raw source inputs (sources 0-31 / 32-63), and writes to them have no effect.
- R7: Offsets 0x60/0x68 return the request vector. A source's bit is 1 exactly when the input is high, the source is enabled, its priority is nonzero and it has a vector.
- R8: The winner is the requesting source with the highest priority, with ties going to the lowest source index. irq_level and irq_code change on the clock edge after the inputs or registers change.
- R9: irq_out is 1 only when a request exists and the winning priority is strictly greater than mask_lvl. irq_level and irq_code show the winner whenever any request exists, and are zero otherwise.
- R10: irq_code = vector number * 0x20. Vector numbers are: sources 0-3 -> 0x12, 0x15, 0x18, 0x1B; 4-7 -> 0x40-0x43; 12-17 -> 0x50-0x55; 18-22 -> 0x32-0x36; 32-38 -> 0x20-0x26; 39-42 -> 0x38-0x3B; 63 -> 0x2B. Sources 8-11, 23-31 and 43-62 have no vector and never request.
- R11: bus_rdata holds the word addressed in the previous cycle. Unmapped or unaligned offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 64 | Level-sensitive source inputs |
| mask_lvl | input | 4 | Current processor mask level |
| line_mode | output | 1 | Control bit 0 |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_level | output | 4 | Priority of the winning source |
| irq_code | output | 12 | Vector code of the winning source |

## Verification
The assertions assume a write lasts a single strobed cycle with an aligned offset. They also assume that mask_lvl and src_in are steady across each clock edge. The bench drives every input on the falling edge and raises bus_we for exactly one cycle per access, so both assumptions hold. Sources stay asserted while their outputs are compared, which lets the registered winner be checked against a model built only from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 12;

  // Fixed source-to-vector number map; 0 marks a source without a vector.
  function automatic logic [VEC_W-1:0] vec_num(input int src);
    logic [VEC_W-1:0] v;
    v = '0;
    if (src == 0)                    v = 8'h12;
    else if (src == 1)               v = 8'h15;
    else if (src == 2)               v = 8'h18;
    else if (src == 3)               v = 8'h1B;
    else if (src >= 4  && src <= 7)  v = VEC_W'(8'h40 + src - 4);
    else if (src >= 12 && src <= 17) v = VEC_W'(8'h50 + src - 12);
    else if (src >= 18 && src <= 22) v = VEC_W'(8'h32 + src - 18);
    else if (src >= 32 && src <= 38) v = VEC_W'(8'h20 + src - 32);
    else if (src >= 39 && src <= 42) v = VEC_W'(8'h38 + src - 39);
    else if (src == 63)              v = 8'h2B;
    return v;
  endfunction
endpackage

// File: rtl/irq_vec_map.sv
module irq_vec_map
  import irq_pkg::*;
#(
  parameter int N_SRC = 64
) (
  output logic [N_SRC-1:0]        has_vec,
  output logic [N_SRC*CODE_W-1:0] code_flat
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [VEC_W-1:0] vn;
    logic [VEC_W+4:0] scaled;
    assign vn         = vec_num(i);
    assign scaled     = {vn, 5'b0};
    assign has_vec[i] = (vn != '0);
    assign code_flat[i*CODE_W +: CODE_W] = scaled[CODE_W-1:0];
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int N_SRC  = 64,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_we,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [N_SRC-1:0]        src_in,
  input  logic [N_SRC-1:0]        pend,
  output logic [N_SRC-1:0]        en_q,
  output logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    ctrl_q
);
  localparam int BANKS     = N_SRC / DATA_W;
  localparam int FIELDS    = DATA_W / PRIO_W;
  localparam int PRIO_REGS = N_SRC / FIELDS;
  localparam int IW        = ADDR_W - 3;
  localparam int IDX_CSET  = 0;
  localparam int IDX_CCLR  = 1;
  localparam int IDX_PRIO  = 2;
  localparam int IDX_SRC   = IDX_PRIO + PRIO_REGS;
  localparam int IDX_REQ   = IDX_SRC + BANKS;
  localparam int IDX_ENS   = IDX_REQ + BANKS;
  localparam int IDX_DIS   = IDX_ENS + BANKS;

  logic [IW-1:0]     word_idx;
  logic              aligned;
  logic              wr;
  logic [DATA_W-1:0] prio_q [PRIO_REGS];
  logic [DATA_W-1:0] rd_next;

  assign word_idx = bus_addr[ADDR_W-1:3];
  assign aligned  = (bus_addr[2:0] == 3'b000);
  assign wr       = bus_we && aligned;

  // control bit: separate set and clear addresses
  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= 1'b0;
    else if (wr && word_idx == IW'(IDX_CSET) && bus_wdata[0]) ctrl_q <= 1'b1;
    else if (wr && word_idx == IW'(IDX_CCLR) && bus_wdata[0]) ctrl_q <= 1'b0;
  end

  // enable banks: write-one-to-set / write-one-to-clear
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) en_q[b*DATA_W +: DATA_W] <= '0;
      else if (wr && word_idx == IW'(IDX_ENS + b))
        en_q[b*DATA_W +: DATA_W] <= en_q[b*DATA_W +: DATA_W] | bus_wdata;
      else if (wr && word_idx == IW'(IDX_DIS + b))
        en_q[b*DATA_W +: DATA_W] <= en_q[b*DATA_W +: DATA_W] & ~bus_wdata;
    end
  end

  // packed priority words
  for (genvar k = 0; k < PRIO_REGS; k++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst) prio_q[k] <= '0;
      else if (wr && word_idx == IW'(IDX_PRIO + k)) prio_q[k] <= bus_wdata;
    end
    assign prio_flat[k*DATA_W +: DATA_W] = prio_q[k];
  end

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (word_idx == IW'(IDX_CSET) || word_idx == IW'(IDX_CCLR))
        rd_next = {{(DATA_W-1){1'b0}}, ctrl_q};
      for (int k = 0; k < PRIO_REGS; k++)
        if (word_idx == IW'(IDX_PRIO + k)) rd_next = prio_q[k];
      for (int b = 0; b < BANKS; b++) begin
        if (word_idx == IW'(IDX_SRC + b)) rd_next = src_in[b*DATA_W +: DATA_W];
        if (word_idx == IW'(IDX_REQ + b)) rd_next = pend[b*DATA_W +: DATA_W];
        if (word_idx == IW'(IDX_ENS + b) || word_idx == IW'(IDX_DIS + b))
          rd_next = en_q[b*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R2: bits written to the low set word are on afterwards
  a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
    (wr && word_idx == IW'(IDX_ENS)) |=>
      ((en_q[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R3: bits written to the low clear word are off afterwards
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (wr && word_idx == IW'(IDX_DIS)) |=>
      ((en_q[DATA_W-1:0] & $past(bus_wdata)) == '0));

  // R5: control set address raises the line-mode bit
  a_r5_ctrl_set: assert property (@(posedge clk) disable iff (rst)
    (wr && word_idx == IW'(IDX_CSET) && bus_wdata[0]) |=> ctrl_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic [N_SRC*CODE_W-1:0] code_flat,
  input  logic [PRIO_W-1:0]       mask_lvl,
  output logic                    irq_out,
  output logic [PRIO_W-1:0]       irq_level,
  output logic [CODE_W-1:0]       irq_code
);
  logic [PRIO_W-1:0] best_p;
  logic [CODE_W-1:0] best_c;
  logic              found;

  // descending scan with >= : equal priority resolves to the lower index
  always_comb begin
    best_p = '0;
    best_c = '0;
    found  = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i] && prio_flat[i*PRIO_W +: PRIO_W] >= best_p) begin
        best_p = prio_flat[i*PRIO_W +: PRIO_W];
        best_c = code_flat[i*CODE_W +: CODE_W];
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      irq_level <= '0;
      irq_code  <= '0;
    end else begin
      irq_out   <= found && (best_p > mask_lvl);
      irq_level <= found ? best_p : '0;
      irq_code  <= found ? best_c : '0;
    end
  end

  // R9: the line never rises at or below the mask level
  a_r9_above_mask: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (irq_level > $past(mask_lvl)));

  // R9: no request pending leaves the outputs idle next cycle
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (!irq_out && irq_level == '0 && irq_code == '0));

  // R10: an asserted line always carries a real vector code
  a_r10_code_nonzero: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (irq_code != '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  src_in,
  input  logic [PRIO_W-1:0] mask_lvl,
  output logic              line_mode,
  output logic              irq_out,
  output logic [PRIO_W-1:0] irq_level,
  output logic [CODE_W-1:0] irq_code
);
  logic [N_SRC-1:0]        en_q;
  logic [N_SRC-1:0]        has_vec;
  logic [N_SRC-1:0]        prio_nz;
  logic [N_SRC-1:0]        pend;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [N_SRC*CODE_W-1:0] code_flat;

  for (genvar i = 0; i < N_SRC; i++) begin : g_nz
    assign prio_nz[i] = |prio_flat[i*PRIO_W +: PRIO_W];
  end

  assign pend = src_in & en_q & prio_nz & has_vec;

  irq_vec_map #(.N_SRC(N_SRC)) u_map (
    .has_vec   (has_vec),
    .code_flat (code_flat)
  );

  irq_regs #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .pend      (pend),
    .en_q      (en_q),
    .prio_flat (prio_flat),
    .ctrl_q    (line_mode)
  );

  irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .prio_flat (prio_flat),
    .code_flat (code_flat),
    .mask_lvl  (mask_lvl),
    .irq_out   (irq_out),
    .irq_level (irq_level),
    .irq_code  (irq_code)
  );

  // R7: a source with zero priority or no vector is never pending
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~(prio_nz & has_vec)) == '0));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic [3:0]  mask_lvl = '0;
  logic        line_mode, irq_out;
  logic [3:0]  irq_level;
  logic [11:0] irq_code;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .src_in(src_in),
    .mask_lvl(mask_lvl), .line_mode(line_mode), .irq_out(irq_out),
    .irq_level(irq_level), .irq_code(irq_code)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_out", irq_out, 0);
    chk("R1 irq_level", irq_level, 0);
    chk("R1 line_mode", line_mode, 0);
    rd(8'h70, d); chk("R1 enable", d, 0);
    rd(8'h10, d); chk("R1 prio", d, 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h70, 32'h5);
    rd(8'h70, d); chk("R2 set", d, 32'h5);
    wr(8'h70, 32'h2);
    rd(8'h70, d); chk("R2 zero bits unchanged", d, 32'h7);
    wr(8'h78, 32'h8000_0000);
    rd(8'h78, d); chk("R2 high bank", d, 32'h8000_0000);
    rd(8'h88, d); chk("R2 read via clear addr", d, 32'h8000_0000);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(8'h80, 32'h1);
    rd(8'h70, d); chk("R3 clear one", d, 32'h6);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h70, d); chk("R3 all off low", d, 0);
    rd(8'h78, d); chk("R3 all off high", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    for (int k = 0; k < 8; k++) wr(8'(8'h10 + 8*k), 32'h1234_5670 + k);
    for (int k = 0; k < 8; k++) begin
      rd(8'(8'h10 + 8*k), d);
      chk("R4 readback", d, 32'h1234_5670 + k);
    end
    for (int k = 0; k < 8; k++) wr(8'(8'h10 + 8*k), 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h00, 32'h0);
    chk("R5 zero write no effect", line_mode, 0);
    wr(8'h00, 32'h1);
    chk("R5 set", line_mode, 1);
    rd(8'h08, d); chk("R5 read", d, 1);
    wr(8'h08, 32'h1);
    chk("R5 clear", line_mode, 0);
  endtask

  task automatic t_src();
    logic [31:0] d;
    src_in = 64'hA5A5_0F0F_1234_5678;
    rd(8'h50, d); chk("R6 low", d, 32'h1234_5678);
    rd(8'h58, d); chk("R6 high", d, 32'hA5A5_0F0F);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, d); chk("R6 read-only", d, 32'h1234_5678);
    rd(8'h98, d); chk("R11 unmapped", d, 0);
    rd(8'h74, d); chk("R11 unaligned", d, 0);
  endtask

  task automatic t_request();
    logic [31:0] d;
    src_in = '1;
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_0030);   // source 1 prio 3
    wr(8'h18, 32'h0001_1111);   // sources 8..11 prio 1 (no vector), 12 prio 1
    rd(8'h60, d); chk("R7 R10 low request", d, 32'h0000_1002);
    rd(8'h68, d); chk("R7 high request", d, 0);
  endtask

  task automatic t_arb();
    settle();
    chk("R8 winner level", irq_level, 3);
    chk("R10 winner code src1", irq_code, 12'h2A0);
    chk("R9 line above mask", irq_out, 1);
    wr(8'h18, 32'h0003_1111);   // source 12 ties at 3
    settle();
    chk("R8 tie lowest index", irq_code, 12'h2A0);
    wr(8'h48, 32'hF000_0000);   // source 63 prio 15
    settle();
    chk("R8 highest wins", irq_level, 4'hF);
    chk("R10 code src63", irq_code, 12'h560);
    @(negedge clk);
    src_in[63] = 1'b0;
    #1;
    chk("R8 not yet changed", irq_level, 4'hF);
    @(negedge clk);
    chk("R8 one cycle later", irq_level, 3);
  endtask

  task automatic t_mask();
    mask_lvl = 4'd3;
    settle();
    chk("R9 equal mask blocks", irq_out, 0);
    chk("R9 level still shown", irq_level, 3);
    mask_lvl = 4'd2;
    settle();
    chk("R9 above mask", irq_out, 1);
    mask_lvl = 4'd0;
  endtask

  task automatic t_codes();
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h88, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_0002);   // source 0 prio 2
    wr(8'h30, 32'h0000_0005);   // source 32 prio 5
    wr(8'h70, 32'h1);
    settle();
    chk("R10 code src0", irq_code, 12'h240);
    wr(8'h78, 32'h1);
    settle();
    chk("R10 code src32", irq_code, 12'h400);
    chk("R4 field of src32", irq_level, 5);
    src_in = '0;
    settle(); settle();
    chk("R9 idle line", irq_out, 0);
    chk("R9 idle code", irq_code, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_disable();
    t_prio();
    t_ctrl();
    t_src();
    t_request();
    t_arb();
    t_mask();
    t_codes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule